// File: doc/BRIEF.md
# Wired-OR Bit-Serial Bus Arbiter

This block settles ownership of a shared backplane line whose level is the logical OR of every node's drive. When its request input rises, the node sends a 10-bit code one bit per arbitration period, most significant bit first. The code is a 4-bit priority followed by a 6-bit node number. Near the end of each period the node reads the resolved line and compares it with the bit it is sending. A node that sent 0 and reads back 1 has met a stronger competitor. It releases the line at once and stays out for the rest of the round. A node whose code survives all ten periods has won.

The node number lives in a small register that clears at reset and is written through a strobe. The code is captured when a round starts, so later changes to the priority input or the node-number register do not affect a round already running. The result, won or lost, is held for as long as the request stays high. Dropping the request returns the block to idle and releases the line. A parameter sets the pin polarity. In the default setting the line is active-low: a logical 1 leaves the pin as a low level, and the sensed pin is inverted back the same way.

Top module: `wor_bus_arbiter`

## Requirements
- R1: While reset is high, and on the first cycle after it, arb_won and arb_lost are 0 and the line is released (line_out = 1 with PIN_ACTIVE_LOW = 1).
- R2: The node-number register is 0 after reset. The register loads id_val on a clock edge where id_wr is 1. A write on the same edge that starts a round does not take part in that round; the round uses the previous value.
- R3: A round starts on the clock edge where arb_req is 1 in idle. The code {arb_prio[3:0], node number[5:0]} is then sent MSB first, bit 9 first. Step j (j = 0..9) carries code bit 9-j and appears on the pin from edge start+j*BIT_CYCLES for BIT_CYCLES clocks.
- R4: On the last clock of each step the sensed bit is compared with the driven bit. On a mismatch (sent 0, read 1), arb_lost rises at edge start+(j+1)*BIT_CYCLES and the line is released for the rest of the round.
- R5: If no mismatch occurs in all ten steps, arb_won rises at edge start+10*BIT_CYCLES and the line is released. arb_won and arb_lost are never 1 together.
- R6: arb_won and arb_lost hold while arb_req stays 1. One edge after arb_req is 0 (in any state, including mid-round), both are 0 and the line is released.
- R7: Changes to arb_prio or writes to the node number during a round do not change that round's bits or its outcome.
- R8: With PIN_ACTIVE_LOW = 1, a logical drive of 1 makes line_out 0, and line_in = 0 is read as a bus level of 1.
- R9: The node with the higher priority wins regardless of node number. With equal priorities the higher node number wins. A competitor with an identical code does not cause a loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arb_req | input | 1 | Request a round; hold high to keep the result |
| arb_prio | input | PRIO_W | Priority captured at round start |
| id_wr | input | 1 | Node-number write strobe |
| id_val | input | NODE_W | Node-number write value |
| line_in | input | 1 | Sensed pin level of the shared line |
| line_out | output | 1 | Pin drive level of the shared line |
| arb_won | output | 1 | Round won, held while arb_req is high |
| arb_lost | output | 1 | Round lost, held while arb_req is high |

## Verification
Two pairs of events can land on the same clock edge. The first pair is a mismatch on the final step and the end of the round. The bench provokes this with a competitor whose code differs from the node's only in the last node-number bit. It then checks that arb_lost rises, not arb_won, on exactly the edge where a win would otherwise have been flagged. The second pair is a node-number write and a round start on the same edge. The bench writes a value that would lose while the register still holds a value that wins. It then checks that the outcome matches the old value.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARB  = 2'd1,
    ST_WON  = 2'd2,
    ST_LOST = 2'd3
  } arb_state_t;
endpackage

// File: rtl/arb_bit_timer.sv
// Counts clocks inside one arbitration step; tick marks the sampling clock.
module arb_bit_timer #(
  parameter int BIT_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic enable,
  output logic tick
);
  localparam int CW = (BIT_CYCLES > 1) ? $clog2(BIT_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(BIT_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign tick = enable && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q <= '0;
    end else if (enable) begin
      cnt_q <= tick ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/arb_code_shifter.sv
// Holds the arbitration code and presents the current and next bit.
module arb_code_shifter #(
  parameter int CODE_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              shift,
  input  logic [CODE_W-1:0] code,
  output logic              cur_bit,
  output logic              next_bit
);
  logic [CODE_W-1:0] sh_q;

  assign cur_bit  = sh_q[CODE_W-1];
  assign next_bit = sh_q[CODE_W-2];

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q <= '0;
    end else if (load) begin
      sh_q <= code;
    end else if (shift) begin
      sh_q <= {sh_q[CODE_W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/arb_pin_adapter.sv
// Maps logical line values to pin levels; the parameter picks the polarity.
module arb_pin_adapter #(
  parameter bit ACTIVE_LOW = 1'b1
) (
  input  logic drive_bit,
  input  logic pin_in,
  output logic pin_out,
  output logic sense_bit
);
  generate
    if (ACTIVE_LOW) begin : g_inv
      assign pin_out   = ~drive_bit;
      assign sense_bit = ~pin_in;
    end else begin : g_pass
      assign pin_out   = drive_bit;
      assign sense_bit = pin_in;
    end
  endgenerate
endmodule

// File: rtl/wor_bus_arbiter.sv
module wor_bus_arbiter
  import arb_pkg::*;
#(
  parameter int PRIO_W         = 4,
  parameter int NODE_W         = 6,
  parameter int BIT_CYCLES     = 4,
  parameter bit PIN_ACTIVE_LOW = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arb_req,
  input  logic [PRIO_W-1:0] arb_prio,
  input  logic              id_wr,
  input  logic [NODE_W-1:0] id_val,
  input  logic              line_in,
  output logic              line_out,
  output logic              arb_won,
  output logic              arb_lost
);
  localparam int CODE_W = PRIO_W + NODE_W;
  localparam int IDX_W  = $clog2(CODE_W);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(CODE_W - 1);

  arb_state_t        st_q;
  logic [NODE_W-1:0] node_id_q;
  logic [IDX_W-1:0]  idx_q;
  logic              drv_q;
  logic              tick;
  logic              cur_bit;
  logic              next_bit;
  logic              sense_bit;
  logic              start;
  logic              mismatch;
  logic [CODE_W-1:0] start_code;

  assign start      = (st_q == ST_IDLE) && arb_req;
  assign start_code = {arb_prio, node_id_q};
  assign mismatch   = drv_q != sense_bit;

  arb_bit_timer #(.BIT_CYCLES(BIT_CYCLES)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .clear  (st_q != ST_ARB),
    .enable (st_q == ST_ARB),
    .tick   (tick)
  );

  arb_code_shifter #(.CODE_W(CODE_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .load     (start),
    .shift    ((st_q == ST_ARB) && tick),
    .code     (start_code),
    .cur_bit  (cur_bit),
    .next_bit (next_bit)
  );

  arb_pin_adapter #(.ACTIVE_LOW(PIN_ACTIVE_LOW)) u_pin (
    .drive_bit (drv_q),
    .pin_in    (line_in),
    .pin_out   (line_out),
    .sense_bit (sense_bit)
  );

  // Node-number register: independent of the round, cleared at reset.
  always_ff @(posedge clk) begin
    if (rst) begin
      node_id_q <= '0;
    end else if (id_wr) begin
      node_id_q <= id_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      drv_q <= 1'b0;
      idx_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          drv_q <= 1'b0;
          if (arb_req) begin
            st_q  <= ST_ARB;
            drv_q <= start_code[CODE_W-1];
            idx_q <= '0;
          end
        end
        ST_ARB: begin
          if (!arb_req) begin
            st_q  <= ST_IDLE;
            drv_q <= 1'b0;
          end else if (tick) begin
            if (mismatch) begin
              st_q  <= ST_LOST;
              drv_q <= 1'b0;
            end else if (idx_q == IDX_LAST) begin
              st_q  <= ST_WON;
              drv_q <= 1'b0;
            end else begin
              drv_q <= next_bit;
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        default: begin
          drv_q <= 1'b0;
          if (!arb_req) st_q <= ST_IDLE;
        end
      endcase
    end
  end

  assign arb_won  = (st_q == ST_WON);
  assign arb_lost = (st_q == ST_LOST);

  // cur_bit mirrors drv_q during a round; kept as an observable tap.
  logic unused_tap;
  assign unused_tap = cur_bit;
endmodule

// File: rtl/wor_bus_arbiter_chk.sv
module wor_bus_arbiter_chk #(
  parameter bit PIN_ACTIVE_LOW = 1'b1
) (
  input logic clk,
  input logic rst,
  input logic arb_req,
  input logic line_in,
  input logic line_out,
  input logic arb_won,
  input logic arb_lost
);
  localparam logic REL = PIN_ACTIVE_LOW;

  // R5: outcome flags are exclusive
  p_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !(arb_won && arb_lost));

  // R4: a lost node leaves the line released
  p_release_lost_r4: assert property (@(posedge clk) disable iff (rst)
    arb_lost |-> (line_out == REL));

  // R5: a winner releases the line after the round
  p_release_won_r5: assert property (@(posedge clk) disable iff (rst)
    arb_won |-> (line_out == REL));

  // R4: a loss follows a sampled disagreement between drive and line
  p_loss_cause_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(arb_lost) |-> $past(line_out != line_in));

  // R5: a win is never declared on a disagreeing sample
  p_win_agree_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(arb_won) |-> $past(line_out == line_in));

  // R6: results hold while the request stays high
  p_hold_won_r6: assert property (@(posedge clk) disable iff (rst)
    (arb_won && arb_req) |=> arb_won);
  p_hold_lost_r6: assert property (@(posedge clk) disable iff (rst)
    (arb_lost && arb_req) |=> arb_lost);

  // R6: dropping the request clears the result and releases the line
  p_drop_r6: assert property (@(posedge clk) disable iff (rst)
    !arb_req |=> (!arb_won && !arb_lost && line_out == REL));
endmodule

bind wor_bus_arbiter wor_bus_arbiter_chk #(.PIN_ACTIVE_LOW(PIN_ACTIVE_LOW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .arb_req  (arb_req),
  .line_in  (line_in),
  .line_out (line_out),
  .arb_won  (arb_won),
  .arb_lost (arb_lost)
);

// File: tb/test_wor_bus_arbiter.sv
`timescale 1ns/1ps
module test_wor_bus_arbiter;
  localparam int B = 4;

  typedef struct {
    bit    won;
    int    cyc;
    string tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       arb_req = 1'b0;
  logic [3:0] arb_prio = '0;
  logic       id_wr = 1'b0;
  logic [5:0] id_val = '0;
  logic       other = 1'b0;
  logic       line_in, line_out, arb_won, arb_lost;
  logic       bus_level;

  int   n_checks = 0;
  int   n_bad = 0;
  int   cyc = 0;
  bit   seen = 1'b0;
  logic [5:0] cur_id = '0;
  exp_t sb_q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // wired-OR line: own logical drive OR the competitors
  assign bus_level = ~line_out | other;
  assign line_in   = ~bus_level;

  wor_bus_arbiter #(.BIT_CYCLES(B)) i_wor_bus_arbiter (
    .clk(clk), .rst(rst), .arb_req(arb_req), .arb_prio(arb_prio),
    .id_wr(id_wr), .id_val(id_val), .line_in(line_in),
    .line_out(line_out), .arb_won(arb_won), .arb_lost(arb_lost)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitor: pops the expected outcome when a result appears
  always @(negedge clk) begin
    if (!rst) begin
      if ((arb_won || arb_lost) && !seen) begin
        exp_t it;
        seen = 1'b1;
        if (sb_q.size() == 0) begin
          chk(1'b0, "R4/R5", "unexpected result", 1, 0);
        end else begin
          it = sb_q.pop_front();
          chk(arb_won == it.won && arb_lost == !it.won, it.tag,
              "outcome won", int'(arb_won), int'(it.won));
          chk(cyc == it.cyc, it.tag, "result edge", cyc, it.cyc);
        end
      end
      if (!arb_won && !arb_lost) seen = 1'b0;
    end
  end

  task automatic write_id(input logic [5:0] v);
    @(negedge clk);
    id_wr = 1'b1; id_val = v;
    @(negedge clk);
    id_wr = 1'b0;
    cur_id = v;
  endtask

  task automatic run_round(input logic [3:0] p, input logic [9:0] c0,
                           input logic [9:0] c1, input logic [9:0] c2,
                           input logic [2:0] cv, input bit disturb,
                           input bit wr_start, input logic [5:0] wr_val,
                           input string tag);
    logic [9:0] codes[4];
    logic [3:0] alive;
    logic [9:0] oth;
    logic [9:0] myb;
    logic       bus;
    int         lose_step;
    int         n0;
    exp_t       it;
    codes[0] = {p, cur_id};
    codes[1] = c0; codes[2] = c1; codes[3] = c2;
    alive = {cv, 1'b1};
    lose_step = -1;
    for (int j = 0; j < 10; j++) begin
      bus = 1'b0; oth[j] = 1'b0;
      for (int n = 0; n < 4; n++) begin
        if (alive[n]) begin
          bus = bus | codes[n][9-j];
          if (n > 0) oth[j] = oth[j] | codes[n][9-j];
        end
      end
      myb[j] = alive[0] ? codes[0][9-j] : 1'b0;
      for (int n = 0; n < 4; n++) begin
        if (alive[n] && !codes[n][9-j] && bus) begin
          alive[n] = 1'b0;
          if (n == 0) lose_step = j;
        end
      end
    end
    @(negedge clk);
    arb_prio = p; arb_req = 1'b1;
    if (wr_start) begin id_wr = 1'b1; id_val = wr_val; end
    n0 = cyc;
    it.won = (lose_step < 0);
    it.cyc = n0 + 1 + ((lose_step < 0) ? 10 : lose_step + 1) * B;
    it.tag = tag;
    sb_q.push_back(it);
    for (int j = 0; j < 10; j++) begin
      if (j == 0) @(negedge clk);
      else repeat (B) @(negedge clk);
      other = oth[j];
      // R3/R8: pin carries the inverted code bit, or released after loss
      chk(line_out == ~myb[j], {tag, " R3 R8"}, $sformatf("pin step %0d", j),
          int'(line_out), int'(~myb[j]));
      if (j == 0 && wr_start) begin id_wr = 1'b0; cur_id = wr_val; end
      if (disturb && j == 1) begin
        arb_prio = 4'hF; id_wr = 1'b1; id_val = 6'h3F;
      end
      if (disturb && j == 2) begin id_wr = 1'b0; cur_id = 6'h3F; end
    end
    repeat (B) @(negedge clk);
    other = 1'b0;
    repeat (2) @(negedge clk);
    chk(arb_won == it.won && arb_lost == !it.won, {tag, " R6"}, "held result",
        int'(arb_won), int'(it.won));
    chk(line_out == 1'b1, {tag, " R6"}, "released while held", int'(line_out), 1);
    arb_req = 1'b0;
    @(negedge clk);
    chk(!arb_won && !arb_lost, {tag, " R6"}, "cleared after drop",
        int'(arb_won | arb_lost), 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!arb_won && !arb_lost, "R1", "flags in reset", int'(arb_won | arb_lost), 0);
    chk(line_out == 1'b1, "R1", "pin in reset", int'(line_out), 1);
    rst = 1'b0;
    @(negedge clk);
    chk(!arb_won && !arb_lost && line_out, "R1", "after reset",
        int'({arb_won, arb_lost, line_out}), 1);

    // R2: default node number 0 wins alone, loses to node 1 on the last bit
    run_round(4'd0, '0, '0, '0, 3'b000, 1'b0, 1'b0, '0, "R2 alone");
    run_round(4'd0, 10'h001, '0, '0, 3'b001, 1'b0, 1'b0, '0, "R2 R4 last-bit loss");

    // R9: equal priority, highest node number wins
    write_id(6'd8);
    run_round(4'd0, 10'd7, 10'd2, '0, 3'b011, 1'b0, 1'b0, '0, "R9 node8 wins");
    write_id(6'd7);
    run_round(4'd0, 10'd8, 10'd2, '0, 3'b011, 1'b0, 1'b0, '0, "R9 R4 node7 loses");

    // R9: priority dominates node number; identical code does not lose
    run_round(4'd5, {4'd3, 6'd63}, '0, '0, 3'b001, 1'b0, 1'b0, '0, "R9 prio wins");
    run_round(4'd3, {4'd5, 6'd1}, '0, '0, 3'b001, 1'b0, 1'b0, '0, "R9 R4 prio loses");
    run_round(4'd2, {4'd2, 6'd7}, '0, '0, 3'b001, 1'b0, 1'b0, '0, "R9 tie");

    // R7: priority and node-number changes mid-round have no effect
    run_round(4'd5, {4'd5, 6'd9}, '0, '0, 3'b001, 1'b1, 1'b0, '0, "R7 disturb");

    // R2: write on the start edge is not used; old id 63 wins
    run_round(4'd0, {4'd0, 6'd10}, '0, '0, 3'b001, 1'b0, 1'b1, 6'd0, "R2 write at start");
    // R2: new id 0 now used; loses to 10
    run_round(4'd0, {4'd0, 6'd10}, '0, '0, 3'b001, 1'b0, 1'b0, '0, "R2 new id");

    // R6: dropping the request mid-round aborts and releases
    write_id(6'd63);
    @(negedge clk);
    arb_prio = 4'hF; arb_req = 1'b1;
    repeat (2 * B) @(negedge clk);
    chk(line_out == 1'b0, "R6 R3", "driving mid-round", int'(line_out), 0);
    arb_req = 1'b0;
    @(negedge clk);
    chk(line_out == 1'b1 && !arb_won && !arb_lost, "R6", "abort released",
        int'({line_out, arb_won, arb_lost}), 4);
    repeat (12 * B) @(negedge clk);
    chk(!arb_won && !arb_lost, "R6", "no result after abort",
        int'(arb_won | arb_lost), 0);
    chk(sb_q.size() == 0, "R4/R5", "scoreboard drained", sb_q.size(), 0);

    $display("test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "R1", "watchdog expired", 1, 0);
    $display("test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end
endmodule